// File: doc/BRIEF.md
# Telephony Codec Reset and Power-Domain Controller

This block decides which sections of a telephony codec device draw power. It holds a small bank of control registers written over a simple register bus. From their contents it derives enables for the filter/codec section, the reference/bias section, three output drivers (handset, speaker, auxiliary output) and the oscillator. It also gates the external clock input and drives the tri-state control of the serial data output. Power for the shared sections is never programmed directly. It is computed from the OR of the path-select bits, so software only chooses routes.

Two resets act on the bank. A power-on reset input is asserted asynchronously and released through a two-stage synchronizer. A software reset bit inside the bank returns every other register to its default and holds it there until software clears the bit. In both cases the device settles in its low-power standby state: all sections off, the oscillator stopped, the external clock blocked and the data output floating. The register port stays usable throughout.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it goes high, the registers hold their defaults (0x0E=0x01, 0x0F=0x00, 0x10=0x01, 0x12=0x00, 0x13=0x00), all enables are 0 and `dout_hiz` is 1. Writes take effect from the third rising edge after release.
- R2: A write of 1 to bit 0 of 0x0F (software reset) returns all other registers to their defaults at that same edge. While the bit is 1, writes to other addresses are ignored and `dout_hiz` is 1.
- R3: The software reset bit stays 1 until a write to 0x0F with bit 0 clear, or until power-on reset.
- R4: Bits 1, 2 and 3 of 0x13 drive `hs_drv_en`, `spk_drv_en` and `auxo_drv_en` respectively; a clear bit leaves that driver disabled (output tri-stated).
- R5: `codec_en` is 1 exactly when some bit of 0x12 or some bit 7..4 of 0x13 is set.
- R6: `refbias_en` is 1 when `codec_en` is 1, any driver is enabled, or bit 0 of 0x13 (auxiliary-input route) is set. With only bit 0 of 0x13 set, `refbias_en` is 1 and `codec_en` is 0.
- R7: `osc_en` is the inverse of bit 0 of 0x0E (power-down, default 1), so the oscillator starts only after software clears that bit.
- R8: `ext_clk_gated` follows `ext_clk_in` while bit 0 of 0x10 is 0, and is held at 0 while that bit is 1.
- R9: With bit 1 of 0x0E clear (serial-strobe mode), `dout_hiz` equals the inverse of `strobe_present`. With it set (bus mode), `dout_hiz` stays 1 until bit 0 of 0x12 (transmit channel) is set.
- R10: `bus_rdata` returns, combinationally, the stored byte of the register at `bus_addr`. Unmapped addresses read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| strobe_present | input | 1 | Serial channel strobe is active |
| ext_clk_in | input | 1 | External clock to be gated |
| codec_en | output | 1 | Filter/codec section power enable |
| refbias_en | output | 1 | Reference/bias section power enable |
| hs_drv_en | output | 1 | Handset driver enable |
| spk_drv_en | output | 1 | Speaker driver enable |
| auxo_drv_en | output | 1 | Auxiliary output driver enable |
| osc_en | output | 1 | Oscillator enable |
| ext_clk_gated | output | 1 | External clock after gating |
| dout_hiz | output | 1 | Data output tri-state control, 1 = floating |

## Verification
The power derivation is tried first with single routes: auxiliary input alone, each driver alone, one transmit bit and one high receive bit. This separates the case where the reference comes up without the codec from the cases where both come up. Mixed and random path bytes then show whether the OR reduction misses or leaks a bit. Software reset is set in the middle of traffic, and other addresses are then written, to show that writes are blocked and the bit is sticky. The data-output control is swept in both modes with the strobe toggling and the transmit channel switched, which separates mode selection from channel enabling.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;
  parameter int NREG   = 5;

  localparam int IX_CTL1 = 0;
  localparam int IX_SRST = 1;
  localparam int IX_CLKG = 2;
  localparam int IX_TXP  = 3;
  localparam int IX_RXP  = 4;

  localparam int CTL1_PD  = 0;
  localparam int CTL1_BUS = 1;
  localparam int SRST_BIT = 0;
  localparam int CLKG_BIT = 0;
  localparam int TX_CHAN  = 0;
  localparam int RX_AUXIN = 0;
  localparam int RX_HS    = 1;
  localparam int RX_SPK   = 2;
  localparam int RX_AUXO  = 3;
  localparam int RX_CODEC_LO = 4;

  function automatic logic [ADDR_W-1:0] reg_addr(input int ix);
    case (ix)
      IX_CTL1: reg_addr = ADDR_W'(8'h0E);
      IX_SRST: reg_addr = ADDR_W'(8'h0F);
      IX_CLKG: reg_addr = ADDR_W'(8'h10);
      IX_TXP:  reg_addr = ADDR_W'(8'h12);
      default: reg_addr = ADDR_W'(8'h13);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_dflt(input int ix);
    case (ix)
      IX_CTL1: reg_dflt = DATA_W'(1) << CTL1_PD;
      IX_CLKG: reg_dflt = DATA_W'(1) << CLKG_BIT;
      default: reg_dflt = '0;
    endcase
  endfunction
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdc_regfile.sv
module pdc_regfile
  import pdc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG-1:0][DATA_W-1:0]   regs,
  output logic [DATA_W-1:0]             rdata
);
  logic srst_now;
  logic srst_set;
  logic hold_dflt;

  assign srst_now  = regs[IX_SRST][SRST_BIT];
  assign srst_set  = wr_en && (addr == reg_addr(IX_SRST)) && wdata[SRST_BIT];
  assign hold_dflt = srst_now || srst_set;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              hit;
    logic              en;
    logic [DATA_W-1:0] d_r;
    logic [DATA_W-1:0] q_r;

    assign hit = wr_en && (addr == reg_addr(i));

    if (i == IX_SRST) begin : g_srst
      always_comb begin
        en  = hit;
        d_r = wdata;
      end
    end else begin : g_ctl
      always_comb begin
        en  = hit || hold_dflt;
        d_r = hold_dflt ? reg_dflt(i) : wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= reg_dflt(i);
      else if (en) q_r <= d_r;
    end

    assign regs[i] = q_r;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      if (addr == reg_addr(k)) rdata = regs[k];
    end
  end

  // R2
  sreset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_now |=> (regs[IX_TXP] == '0 && regs[IX_RXP] == '0 &&
                  regs[IX_CTL1] == reg_dflt(IX_CTL1) && regs[IX_CLKG] == reg_dflt(IX_CLKG)));

  // R3
  sreset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_now && !(wr_en && addr == reg_addr(IX_SRST) && !wdata[SRST_BIT])) |=> srst_now);
endmodule

// File: rtl/pdc_power_logic.sv
module pdc_power_logic
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_active,
  input  logic              srst,
  input  logic              pd,
  input  logic              bus_mode,
  input  logic              clk_block,
  input  logic [DATA_W-1:0] tx_path,
  input  logic [DATA_W-1:0] rx_path,
  input  logic              strobe_present,
  output logic              codec_en,
  output logic              refbias_en,
  output logic              hs_drv_en,
  output logic              spk_drv_en,
  output logic              auxo_drv_en,
  output logic              osc_en,
  output logic              clk_allow,
  output logic              dout_hiz
);
  logic any_drv;
  logic dout_idle;

  always_comb begin
    codec_en    = (|tx_path) || (|rx_path[DATA_W-1:RX_CODEC_LO]);
    hs_drv_en   = rx_path[RX_HS];
    spk_drv_en  = rx_path[RX_SPK];
    auxo_drv_en = rx_path[RX_AUXO];
    any_drv     = hs_drv_en || spk_drv_en || auxo_drv_en;
    refbias_en  = codec_en || any_drv || rx_path[RX_AUXIN];
    osc_en      = !pd;
    clk_allow   = !clk_block;
    dout_idle   = bus_mode ? !tx_path[TX_CHAN] : !strobe_present;
    dout_hiz    = por_active || srst || dout_idle;
  end

  // R6
  refbias_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (codec_en || hs_drv_en || spk_drv_en || auxo_drv_en) |-> refbias_en);

  // R2
  srst_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (dout_hiz && !codec_en && !refbias_en));
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              strobe_present,
  input  logic              ext_clk_in,
  output logic              codec_en,
  output logic              refbias_en,
  output logic              hs_drv_en,
  output logic              spk_drv_en,
  output logic              auxo_drv_en,
  output logic              osc_en,
  output logic              ext_clk_gated,
  output logic              dout_hiz
);
  logic                        por_n;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic                        clk_allow;

  pdc_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (por_n)
  );

  pdc_regfile u_regs (
    .clk   (clk),
    .rst_n (por_n),
    .wr_en (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .regs  (regs),
    .rdata (bus_rdata)
  );

  pdc_power_logic u_pwr (
    .clk            (clk),
    .rst_n          (por_n),
    .por_active     (!por_n),
    .srst           (regs[IX_SRST][SRST_BIT]),
    .pd             (regs[IX_CTL1][CTL1_PD]),
    .bus_mode       (regs[IX_CTL1][CTL1_BUS]),
    .clk_block      (regs[IX_CLKG][CLKG_BIT]),
    .tx_path        (regs[IX_TXP]),
    .rx_path        (regs[IX_RXP]),
    .strobe_present (strobe_present),
    .codec_en       (codec_en),
    .refbias_en     (refbias_en),
    .hs_drv_en      (hs_drv_en),
    .spk_drv_en     (spk_drv_en),
    .auxo_drv_en    (auxo_drv_en),
    .osc_en         (osc_en),
    .clk_allow      (clk_allow),
    .dout_hiz       (dout_hiz)
  );

  assign ext_clk_gated = ext_clk_in && clk_allow;

  // R7
  osc_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(osc_en) |-> $past(bus_we && bus_addr == reg_addr(IX_CTL1) && !bus_wdata[CTL1_PD]));

  // R8
  clk_block_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_we && bus_addr == reg_addr(IX_CLKG) && bus_wdata[CLKG_BIT] && !regs[IX_SRST][SRST_BIT])
      |=> !clk_allow);
endmodule

// File: tb/tb_pwr_domain_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_domain_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       strobe_present = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       codec_en, refbias_en, hs_drv_en, spk_drv_en, auxo_drv_en;
  logic       osc_en, ext_clk_gated, dout_hiz;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] m0e = 8'h01, m0f = 8'h00, m10 = 8'h01, m12 = 8'h00, m13 = 8'h00;
  int por_cnt = 0;

  pwr_domain_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strobe_present(strobe_present),
    .ext_clk_in(ext_clk_in), .codec_en(codec_en), .refbias_en(refbias_en),
    .hs_drv_en(hs_drv_en), .spk_drv_en(spk_drv_en), .auxo_drv_en(auxo_drv_en),
    .osc_en(osc_en), .ext_clk_gated(ext_clk_gated), .dout_hiz(dout_hiz)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1 ext_clk_in <= ~ext_clk_in;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic set_defaults();
    m0e = 8'h01; m0f = 8'h00; m10 = 8'h01; m12 = 8'h00; m13 = 8'h00;
  endtask

  // model update, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt = 0;
      set_defaults();
    end else begin
      if (por_cnt == 2 && bus_we) begin
        if (bus_addr == 8'h0F) begin
          if (bus_wdata[0] || m0f[0]) begin
            m0e = 8'h01; m10 = 8'h01; m12 = 8'h00; m13 = 8'h00;
          end
          m0f = bus_wdata;
        end else if (!m0f[0]) begin
          case (bus_addr)
            8'h0E: m0e = bus_wdata;
            8'h10: m10 = bus_wdata;
            8'h12: m12 = bus_wdata;
            8'h13: m13 = bus_wdata;
            default: ;
          endcase
        end
      end
      if (por_cnt < 2) por_cnt++;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    logic por, srst, e_codec, e_ref, e_hiz, e_clk;
    logic [7:0] e_rd;
    string t;
    cyc++;
    por  = (por_cnt < 2);
    srst = m0f[0];
    e_codec = (m12 != 0) || (m13[7:4] != 0);
    e_ref   = e_codec || m13[1] || m13[2] || m13[3] || m13[0];
    e_clk   = ext_clk_in && !m10[0];
    e_hiz   = por || srst || (m0e[1] ? !m12[0] : !strobe_present);
    case (bus_addr)
      8'h0E: e_rd = m0e; 8'h0F: e_rd = m0f; 8'h10: e_rd = m10;
      8'h12: e_rd = m12; 8'h13: e_rd = m13; default: e_rd = 8'h00;
    endcase
    t = por ? "R1" : (srst ? "R2" : "");
    chk(t == "" ? "R5 codec_en" : {t, " codec_en"}, {7'd0, codec_en}, {7'd0, e_codec});
    chk(t == "" ? "R6 refbias_en" : {t, " refbias_en"}, {7'd0, refbias_en}, {7'd0, e_ref});
    chk(t == "" ? "R4 drivers" : {t, " drivers"},
        {5'd0, auxo_drv_en, spk_drv_en, hs_drv_en}, {5'd0, m13[3], m13[2], m13[1]});
    chk(t == "" ? "R7 osc_en" : {t, " osc_en"}, {7'd0, osc_en}, {7'd0, !m0e[0]});
    chk(t == "" ? "R8 ext_clk_gated" : {t, " ext_clk_gated"}, {7'd0, ext_clk_gated}, {7'd0, e_clk});
    chk(t == "" ? "R9 dout_hiz" : {t, " dout_hiz"}, {7'd0, dout_hiz}, {7'd0, e_hiz});
    chk(t != "" ? {t, " rdata"} : (bus_addr == 8'h0F ? "R3 rdata" : "R10 rdata"), bus_rdata, e_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: writes during synchronizer release must be dropped
    rst_n = 1'b1;
    wr(8'h12, 8'hFF);
    wr(8'h13, 8'hFF);
    idle(1);
    @(negedge clk); chk("R1 reset defaults kept", bus_rdata, 8'h00);
    @(posedge clk); #1;
    rd(8'h0E); rd(8'h0F); rd(8'h10); rd(8'h12); rd(8'h13); rd(8'h11);
    // R6: auxiliary input alone
    wr(8'h13, 8'h01);
    @(negedge clk); chk("R6 aux-only ref on", {7'd0, refbias_en}, 8'h01);
    chk("R6 aux-only codec off", {7'd0, codec_en}, 8'h00);
    @(posedge clk); #1;
    // R4: each driver alone
    wr(8'h13, 8'h02); wr(8'h13, 8'h04); wr(8'h13, 8'h08);
    // R5: high receive bit, each transmit bit
    wr(8'h13, 8'h40);
    for (int b = 0; b < 8; b++) wr(8'h12, 8'h01 << b);
    wr(8'h12, 8'h00); wr(8'h13, 8'h00);
    // R7 / R8
    wr(8'h0E, 8'h00); idle(3);
    wr(8'h10, 8'h00); idle(4);
    wr(8'h10, 8'h01); idle(2);
    // R9: serial-strobe mode
    for (int i = 0; i < 6; i++) begin strobe_present = i[0]; idle(1); end
    // R9: bus mode, transmit channel off then on
    wr(8'h0E, 8'h02); strobe_present = 1'b1; idle(2);
    wr(8'h12, 8'h01); idle(2);
    wr(8'h12, 8'h80); idle(2);
    // R2/R3: software reset in the middle of traffic
    wr(8'h12, 8'h11); wr(8'h13, 8'h0F); wr(8'h10, 8'h00);
    wr(8'h0F, 8'h01);
    wr(8'h13, 8'hFF); wr(8'h0E, 8'h00); wr(8'h12, 8'h01);
    rd(8'h0F);
    wr(8'h0F, 8'h03); rd(8'h13);
    wr(8'h0F, 8'h00); rd(8'h0F);
    wr(8'h13, 8'h0E); idle(2);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, d;
      case ($urandom_range(0, 6))
        0: a = 8'h0E; 1: a = 8'h0F; 2: a = 8'h10; 3: a = 8'h12;
        4: a = 8'h13; 5: a = 8'h11; default: a = 8'h13;
      endcase
      d = 8'($urandom);
      if (a == 8'h0F && $urandom_range(0, 3) != 0) d[0] = 1'b0;
      strobe_present = 1'($urandom);
      if ($urandom_range(0, 2) != 0) wr(a, d); else rd(a);
    end
    // R1: power-on reset in the middle of activity
    wr(8'h13, 8'hFF); wr(8'h0E, 8'h00);
    rst_n = 1'b0; idle(2);
    rst_n = 1'b1; idle(4);
    rd(8'h13);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule